// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block turns one multi-register memory transfer into a series of single-word memory beats. A caller presents a 16-bit register selection mask, a base address, a direction (load or store) and a writeback enable, then pulses `start`. The sequencer picks the selected registers from lowest number to highest. It issues one beat per register, each with the register number and a word address. The addresses begin at the base and step up by one word (4 bytes) per beat.

Each beat is held on the request outputs until the memory side acknowledges it, so memory latency may be any number of cycles. After the final acknowledge the block raises `done` for one cycle. In that same cycle it presents the updated base value for writeback. It also flags when the program counter, register 15, was among the registers loaded, because that load acts as a return. A transfer with an empty mask finishes at once, with no beats.

Top module: `lsm_seq`

## Requirements
- R1: Beats are issued in strictly ascending register number (`req_reg`), one beat for each set bit of the mask and no other beats, whatever the pattern of set bits.
- R2: The first beat carries `req_addr` equal to the base address. Each later beat carries the previous beat's address plus 4, modulo 2^32.
- R3: A beat's `req_reg`, `req_addr` and `req_write` stay unchanged until the cycle in which `req_ack` is high. `req_write` is 1 for a store (`is_load`=0) and 0 for a load.
- R4: `done` is high for exactly one cycle: the cycle right after the clock edge that accepts the final acknowledge.
- R5: When writeback is enabled, `wb_valid` is high together with `done`, and `wb_value` equals base + 4 × (number of set mask bits). With four registers this is base+16.
- R6: When writeback is disabled, `wb_valid` stays low, including in the `done` cycle.
- R7: An all-zero mask produces no beats. `done` is high in the cycle after the edge that samples `start`, and `wb_value` equals the unchanged base.
- R8: `pc_loaded` is high together with `done` only when the transfer was a load and mask bit 15 was set. It is low for stores and for masks without bit 15.
- R9: While `busy` is high, `start` and changes to the operand inputs have no effect on the running transfer or on later ones.
- R10: After reset, `busy`, `req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; taken only while idle |
| reg_mask | input | 16 | Register selection, bit n selects register n |
| base_addr | input | 32 | Base word address |
| is_load | input | 1 | 1 = load from memory, 0 = store |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Transfer in progress |
| req_valid | output | 1 | Memory beat pending |
| req_reg | output | 4 | Register number of the pending beat |
| req_addr | output | 32 | Word address of the pending beat |
| req_write | output | 1 | Pending beat is a store |
| req_ack | input | 1 | Memory accepts the pending beat |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback value is to be applied |
| wb_value | output | 32 | Final base value |
| pc_loaded | output | 1 | Register 15 was loaded (return) |

## Verification
The hardest case to reach is the boundary between beats. The walking mask loses its lowest bit at the same edge that takes an acknowledge, and the last acknowledge must lead straight into the completion cycle. The bench's memory responder acknowledges after a programmable wait, from zero cycles (back-to-back beats) to several. Sparse, dense and single-bit masks, including bit 15 alone and all sixteen bits, put the final bit at different positions. Restarting with a different mask in mid-transfer shows whether operand capture is properly locked.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } lsm_state_e;
endpackage

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  hot
);
  logic [N-1:0] below;

  // below[i] is set when some bit under position i is set
  assign below[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_below
    assign below[g] = below[g-1] | vec[g-1];
  end

  for (genvar g = 0; g < N; g++) begin : g_hot
    assign hot[g] = vec[g] & ~below[g];
  end

  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hot[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mask_zero,
  input  logic       beat_fire,
  input  logic       beat_last,
  output lsm_state_e state_q,
  output logic       accept
);
  lsm_state_e state_d;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = mask_zero ? ST_DONE : ST_BEAT;
      ST_BEAT: if (beat_fire && beat_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R7
  empty_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mask_zero) |=> (state_q == ST_DONE));
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int RW        = $clog2(NREG),
  localparam int CW        = $clog2(NREG + 1),
  localparam int PC_IDX    = NREG - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NREG-1:0]   reg_mask,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              is_load,
  input  logic              wb_en,
  output logic              busy,
  output logic              req_valid,
  output logic [RW-1:0]     req_reg,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  input  logic              req_ack,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_value,
  output logic              pc_loaded
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  lsm_state_e state_q;
  logic       accept;
  logic       beat_fire;
  logic       beat_last;
  logic       mask_zero;

  logic [NREG-1:0]   work_q, work_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] wbv_q,  wbv_d;
  logic              ld_q, wbe_q, pc_q;

  logic              any_bit;
  logic [RW-1:0]     low_idx;
  logic [NREG-1:0]   low_hot;
  logic [CW-1:0]     sel_cnt;
  logic [NREG-1:0]   work_rest;

  lsm_lowbit #(.N(NREG)) i_lowbit (
    .vec (work_q),
    .any (any_bit),
    .idx (low_idx),
    .hot (low_hot)
  );

  lsm_popcnt #(.N(NREG)) i_popcnt (
    .vec (reg_mask),
    .cnt (sel_cnt)
  );

  assign mask_zero = (reg_mask == '0);
  assign work_rest = work_q & ~low_hot;
  assign beat_last = (work_rest == '0);
  assign beat_fire = req_valid && req_ack;

  lsm_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mask_zero (mask_zero),
    .beat_fire (beat_fire),
    .beat_last (beat_last),
    .state_q   (state_q),
    .accept    (accept)
  );

  // next-state of the datapath, enables written out
  always_comb begin
    work_d = work_q;
    addr_d = addr_q;
    wbv_d  = wbv_q;
    if (accept) begin
      work_d = reg_mask;
      addr_d = base_addr;
      wbv_d  = base_addr + ADDR_W'(sel_cnt) * STEP;
    end else if (beat_fire) begin
      work_d = work_rest;
      addr_d = addr_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      addr_q <= '0;
      wbv_q  <= '0;
      ld_q   <= 1'b0;
      wbe_q  <= 1'b0;
      pc_q   <= 1'b0;
    end else begin
      work_q <= work_d;
      addr_q <= addr_d;
      wbv_q  <= wbv_d;
      if (accept) begin
        ld_q  <= is_load;
        wbe_q <= wb_en;
        pc_q  <= is_load & reg_mask[PC_IDX];
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_BEAT) && any_bit;
  assign req_reg   = low_idx;
  assign req_addr  = addr_q;
  assign req_write = ~ld_q;
  assign done      = (state_q == ST_DONE);
  assign wb_valid  = done & wbe_q;
  assign wb_value  = wbv_q;
  assign pc_loaded = done & pc_q;

  // R1
  ascend_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> (!req_valid || (req_reg > $past(req_reg))));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> (!req_valid || (req_addr == $past(req_addr) + STEP)));

  // R3
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=>
      (req_valid && $stable(req_reg) && $stable(req_addr) && $stable(req_write)));

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_last) |=> (done && !req_valid));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  pc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_loaded |-> (done && !req_write));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !done));

  // R9
  busy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> $stable(wb_value));
endmodule

// File: tb/test_lsm_seq.sv
module test_lsm_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] reg_mask;
  logic [31:0] base_addr;
  logic        is_load;
  logic        wb_en;
  logic        busy;
  logic        req_valid;
  logic [3:0]  req_reg;
  logic [31:0] req_addr;
  logic        req_write;
  logic        req_ack;
  logic        done;
  logic        wb_valid;
  logic [31:0] wb_value;
  logic        pc_loaded;

  always #10 clk = ~clk;  // 50 MHz

  lsm_seq i_lsm_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask),
    .base_addr(base_addr), .is_load(is_load), .wb_en(wb_en), .busy(busy),
    .req_valid(req_valid), .req_reg(req_reg), .req_addr(req_addr),
    .req_write(req_write), .req_ack(req_ack), .done(done),
    .wb_valid(wb_valid), .wb_value(wb_value), .pc_loaded(pc_loaded)
  );

  typedef struct { logic [3:0] r; logic [31:0] a; logic w; } beat_t;
  typedef struct { logic v; logic [31:0] val; logic pc; } fin_t;

  beat_t beat_q[$];
  fin_t  fin_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int ack_lat = 0;
  int done_cnt = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R4", "watchdog expired", cyc, 150000);
      wrap_up();
    end
  end

  // monitor and memory responder
  bit ack_d = 0, seen = 0, prev_done = 0;
  int wait_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_d) begin
        ack_d = 0; req_ack = 0; seen = 0;
        if (!req_valid) chk(done == 1'b1, "R4", "done after final ack", done, 1);
      end
      if (req_valid) begin
        if (!seen) begin
          if (beat_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected beat reg", req_reg, 0);
          end else begin
            beat_t e;
            e = beat_q.pop_front();
            chk(req_reg == e.r, "R1", "beat register", req_reg, e.r);
            chk(req_addr == e.a, "R2", "beat address", req_addr, e.a);
            chk(req_write == e.w, "R3", "beat direction", req_write, e.w);
          end
          seen = 1;
          wait_cnt = ack_lat;
        end
        if (wait_cnt == 0) begin req_ack = 1; ack_d = 1; end
        else wait_cnt--;
      end
      if (done) begin
        chk(!prev_done, "R4", "done single cycle", prev_done, 0);
        chk(beat_q.size() == 0, "R1", "beats left at done", beat_q.size(), 0);
        if (fin_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected completion", 1, 0);
        end else begin
          fin_t f;
          f = fin_q.pop_front();
          chk(wb_valid == f.v, f.v ? "R5" : "R6", "wb_valid", wb_valid, f.v);
          if (f.v) chk(wb_value == f.val, "R5", "wb_value", wb_value, f.val);
          chk(pc_loaded == f.pc, "R8", "pc_loaded", pc_loaded, f.pc);
        end
        done_cnt++;
      end
      prev_done = done;
    end
  end

  // driver: queues expected items, then launches the transfer
  task automatic run_op(input logic [15:0] m, input logic [31:0] b,
                        input logic ld, input logic wb, input int lat,
                        input bit meddle);
    logic [31:0] a = b;
    int n = 0;
    int prev;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        beat_q.push_back('{r: 4'(i), a: a, w: !ld});
        a = a + 32'd4;
        n++;
      end
    end
    fin_q.push_back('{v: wb, val: b + 32'(n) * 32'd4, pc: ld & m[15]});
    ack_lat = lat;
    @(negedge clk);
    while (busy) @(negedge clk);
    prev = done_cnt;
    reg_mask = m; base_addr = b; is_load = ld; wb_en = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == 16'h0) begin
      chk(done == 1'b1, "R7", "empty mask done", done, 1);
      chk(req_valid == 1'b0, "R7", "empty mask no beat", req_valid, 0);
      if (wb) chk(wb_value == b, "R7", "empty mask base kept", wb_value, b);
    end
    if (meddle && busy) begin
      reg_mask = ~m; base_addr = 32'hDEAD_0000; is_load = !ld; wb_en = !wb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == prev) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; reg_mask = '0; base_addr = '0;
    is_load = 1'b0; wb_en = 1'b0; req_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R10
    chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
    chk(req_valid == 1'b0, "R10", "req_valid in reset", req_valid, 0);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10", "busy after reset", busy, 0);

    run_op(16'h00F0, 32'h0000_1000, 1'b1, 1'b1, 0, 0);   // R5 four regs -> base+16
    run_op(16'h8421, 32'h0000_2000, 1'b0, 1'b1, 2, 0);   // R1 sparse, store, R8 store
    run_op(16'hFFFF, 32'h0000_4000, 1'b1, 1'b1, 1, 0);   // R8 pc loaded
    run_op(16'h8000, 32'h0000_5000, 1'b1, 1'b0, 3, 0);   // R6 no writeback, pc only
    run_op(16'h0000, 32'h0000_6000, 1'b1, 1'b1, 0, 0);   // R7 empty
    run_op(16'h0001, 32'h0000_7000, 1'b0, 1'b0, 0, 0);   // R6 single reg
    run_op(16'h0306, 32'hFFFF_FFF8, 1'b1, 1'b1, 0, 0);   // R2 wraps
    run_op(16'h1248, 32'h0000_8000, 1'b1, 1'b1, 2, 1);   // R9 start while busy
    run_op(16'h0000, 32'h0000_9000, 1'b0, 1'b0, 0, 0);   // R7 empty no wb
    run_op(16'h7FFE, 32'h0000_A000, 1'b0, 1'b1, 0, 1);   // R9 back-to-back acks

    repeat (4) @(negedge clk);
    chk(beat_q.size() == 0, "R1", "beats never issued", beat_q.size(), 0);
    chk(fin_q.size() == 0, "R4", "completions missing", fin_q.size(), 0);
    chk(busy == 1'b0, "R9", "idle at end", busy, 0);
    wrap_up();
  end
endmodule